// File: doc/BRIEF.md
# Attenuation Pulse-Width Status Encoder

This block reports a coarse line-attenuation estimate on one serial status pin. The receive equalizer hands it a 2-bit attenuation code with a one-cycle update strobe. The block repeats the code continuously as a stream of fixed-length frames. In each frame the pin goes high for a number of receive-clock periods that names the attenuation band, and then stays low for the rest of the frame.

The mapping is as follows. Code 1 gives a one-period pulse (about 7.5 dB). Code 2 gives two periods (about 15 dB). Code 3 gives three periods (about 22.5 dB). Code 0 gives four periods (0 dB). With the default 8-cycle frame, every pulse is followed by at least four low periods, so a listener can separate consecutive pulses. A new code is adopted only at a frame boundary, so a pulse that is already on the pin is never cut short or lengthened.

Top module: `atten_pulse_encoder`

## Requirements
- R1: The pulse lasts 1, 2 or 3 receive-clock periods for codes 1, 2 and 3, and 4 periods for code 0.
- R2: Each frame is 8 rising edges long. The pulse occupies the first periods of the frame and is one contiguous run. Every other period of the frame is low, which leaves at least 4 low periods.
- R3: The first frame starts at the first rising edge after reset is released, and frames then follow each other with no gap.
- R4: The code on the code input is stored when the strobe is high at a rising edge, and it is used from the next frame start on. A strobe sampled on the frame-start edge itself applies to the frame that begins on that edge. A strobe on the last edge of a frame applies to the following frame.
- R5: A strobe during a frame does not change the length of that frame's pulse.
- R6: Changes on the code input while the strobe is low are ignored. The stored code keeps repeating frame after frame.
- R7: When several strobes fall within one frame, the last one before the next frame start decides the next pulse.
- R8: While reset is low, the output is low. Reset clears the frame position and sets the stored code to 0, so the first frame after reset carries a 4-period pulse.
- R9: The output comes straight from a register clocked by the rising receive-clock edge, so it is stable and valid at every rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rx | input | 1 | Receive clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| atten_code | input | 2 | Attenuation band code from the equalizer |
| code_upd | input | 1 | One-cycle strobe that stores atten_code |
| atten_pulse | output | 1 | Serial status line carrying the width-encoded pulse |

## Verification
The bound checker watches the pin on every cycle. It checks that the output is low during reset and that every pulse length falls within the legal range. It also checks that each low gap is at least four periods, that consecutive pulse starts are exactly one frame apart, and that the first pulse appears on the first edge after reset. Some behaviours need knowledge of which code was strobed and when, so only the bench scenarios can show them. These are the exact mapping from code to width, when a stored code takes effect, mid-frame strobes that leave the current pulse alone, the last-strobe-wins rule, and code changes that are ignored without a strobe.

// File: rtl/atten_enc_pkg.sv
package atten_enc_pkg;

   // When a strobe that coincides with the frame-start edge takes effect.
   typedef enum logic [0:0] {
      CAP_NEXT_FRAME = 1'b0,
      CAP_SAME_EDGE  = 1'b1
   } cap_mode_e;

   // Shortest frame that fits the longest pulse plus the required low gap.
   function automatic int unsigned min_frame_len(int unsigned code_w, int unsigned min_low);
      return (32'd1 << code_w) + min_low;
   endfunction

endpackage

// File: rtl/atten_code_hold.sv
module atten_code_hold
   import atten_enc_pkg::*;
#(
   parameter int unsigned CODE_W   = 2,
   parameter cap_mode_e   CAP_MODE = CAP_SAME_EDGE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_in,
   input  logic              upd,
   output logic [CODE_W-1:0] code_sel
);

   logic [CODE_W-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (upd) begin
         pend_q <= code_in;
      end
   end

   generate
      if (CAP_MODE == CAP_SAME_EDGE) begin : g_bypass
         assign code_sel = upd ? code_in : pend_q;
      end else begin : g_stored
         assign code_sel = pend_q;
      end
   endgenerate

endmodule

// File: rtl/atten_frame_timer.sv
module atten_frame_timer #(
   parameter int unsigned FRAME_LEN = 8,
   localparam int unsigned CNT_W    = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] pos,
   output logic             frame_start
);

   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

   logic [CNT_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (pos_q == LAST_POS) begin
         pos_q <= '0;
      end else begin
         pos_q <= pos_q + 1'b1;
      end
   end

   assign pos         = pos_q;
   assign frame_start = (pos_q == '0);

endmodule

// File: rtl/atten_pulse_shaper.sv
module atten_pulse_shaper #(
   parameter int unsigned CODE_W    = 2,
   parameter int unsigned FRAME_LEN = 8,
   localparam int unsigned CNT_W    = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_sel,
   input  logic              frame_start,
   input  logic [CNT_W-1:0]  pos,
   output logic              pulse
);

   // Code zero carries the longest pulse, one past the largest nonzero code.
   localparam logic [CNT_W-1:0] ZERO_CODE_W = CNT_W'(2 ** CODE_W);

   logic [CODE_W-1:0] act_q;
   logic [CNT_W-1:0]  width;
   logic              pulse_q;

   always_comb begin
      if (act_q == '0) begin
         width = ZERO_CODE_W;
      end else begin
         width = CNT_W'(act_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= '0;
         pulse_q <= 1'b0;
      end else if (frame_start) begin
         act_q   <= code_sel;
         pulse_q <= 1'b1;
      end else begin
         pulse_q <= (pos < width);
      end
   end

   assign pulse = pulse_q;

endmodule

// File: rtl/atten_pulse_encoder.sv
module atten_pulse_encoder
   import atten_enc_pkg::*;
#(
   parameter int unsigned CODE_W    = 2,
   parameter int unsigned FRAME_LEN = 8,
   parameter int unsigned MIN_LOW   = 4,
   parameter cap_mode_e   CAP_MODE  = CAP_SAME_EDGE
) (
   input  logic              clk_rx,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] atten_code,
   input  logic              code_upd,
   output logic              atten_pulse
);

   localparam int unsigned CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

   generate
      if (CODE_W < 1) begin : g_bad_code_w
         $error("atten_pulse_encoder: CODE_W must be at least 1");
      end
      if (MIN_LOW < 1) begin : g_bad_min_low
         $error("atten_pulse_encoder: MIN_LOW must be at least 1");
      end
      if (FRAME_LEN < min_frame_len(CODE_W, MIN_LOW)) begin : g_bad_frame
         $error("atten_pulse_encoder: FRAME_LEN too short for longest pulse plus gap");
      end
   endgenerate

   logic [CODE_W-1:0] code_sel;
   logic [CNT_W-1:0]  pos;
   logic              frame_start;

   atten_code_hold #(
      .CODE_W   (CODE_W),
      .CAP_MODE (CAP_MODE)
   ) u_hold (
      .clk      (clk_rx),
      .rst_n    (rst_n),
      .code_in  (atten_code),
      .upd      (code_upd),
      .code_sel (code_sel)
   );

   atten_frame_timer #(
      .FRAME_LEN (FRAME_LEN)
   ) u_timer (
      .clk         (clk_rx),
      .rst_n       (rst_n),
      .pos         (pos),
      .frame_start (frame_start)
   );

   atten_pulse_shaper #(
      .CODE_W    (CODE_W),
      .FRAME_LEN (FRAME_LEN)
   ) u_shaper (
      .clk         (clk_rx),
      .rst_n       (rst_n),
      .code_sel    (code_sel),
      .frame_start (frame_start),
      .pos         (pos),
      .pulse       (atten_pulse)
   );

endmodule

// File: rtl/atten_pulse_checker.sv
module atten_pulse_checker #(
   parameter int unsigned CODE_W    = 2,
   parameter int unsigned FRAME_LEN = 8,
   parameter int unsigned MIN_LOW   = 4
) (
   input logic clk,
   input logic rst_n,
   input logic pulse
);

   localparam int unsigned RW     = $clog2(FRAME_LEN) + 2;
   localparam logic [RW-1:0] SAT  = {RW{1'b1}};
   localparam logic [RW-1:0] MAXW = RW'(2 ** CODE_W);
   localparam logic [RW-1:0] FLEN = RW'(FRAME_LEN);
   localparam logic [RW-1:0] MLOW = RW'(MIN_LOW);

   logic [RW-1:0] hi_run, lo_run, last_hi;
   logic          seen_hi;
   logic [1:0]    boot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run  <= '0;
         lo_run  <= '0;
         last_hi <= '0;
         seen_hi <= 1'b0;
         boot    <= 2'b01;
      end else begin
         boot <= {boot[0], 1'b0};
         if (pulse) begin
            hi_run  <= (hi_run == SAT) ? SAT : hi_run + 1'b1;
            lo_run  <= '0;
            seen_hi <= 1'b1;
         end else begin
            lo_run <= (lo_run == SAT) ? SAT : lo_run + 1'b1;
            hi_run <= '0;
            if (hi_run != '0) last_hi <= hi_run;
         end
      end
   end

   assert_reset_low_R8: assert property (@(posedge clk) !rst_n |-> !pulse);

   assert_width_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse) |-> (hi_run >= 1 && hi_run <= MAXW));

   assert_low_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pulse) && seen_hi) |-> (lo_run >= MLOW));

   assert_frame_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pulse) && seen_hi) |-> ((last_hi + lo_run) == FLEN));

   assert_first_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      boot[1] |-> pulse);

endmodule

bind atten_pulse_encoder atten_pulse_checker #(
   .CODE_W    (CODE_W),
   .FRAME_LEN (FRAME_LEN),
   .MIN_LOW   (MIN_LOW)
) u_chk (
   .clk   (clk_rx),
   .rst_n (rst_n),
   .pulse (atten_pulse)
);

// File: tb/sim_atten_pulse_encoder.sv
`timescale 1ns/100ps
module sim_atten_pulse_encoder;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd   = 1'b0;
   logic [1:0] code  = 2'd0;
   logic       pulse;

   int errs   = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   atten_pulse_encoder u0 (
      .clk_rx      (clk),
      .rst_n       (rst_n),
      .atten_code  (code),
      .code_upd    (upd),
      .atten_pulse (pulse)
   );

   // {code, expected pulse width}
   localparam logic [4:0] VEC [6] = '{
      {2'd1, 3'd1}, {2'd2, 3'd2}, {2'd3, 3'd3},
      {2'd0, 3'd4}, {2'd3, 3'd3}, {2'd1, 3'd1}
   };

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Runs one 8-edge frame, starting just before its frame-start edge.
   // sa/sb: edge index within the frame at which to strobe (-1 = none).
   task automatic frame(input int sa, input logic [1:0] sca,
                        input int sb, input logic [1:0] scb,
                        output int w, output int pre);
      logic [7:0] s;
      w = 0;
      for (int i = 0; i < 8; i++) begin
         if (i == sa) begin upd = 1'b1; code = sca; end
         if (i == sb) begin upd = 1'b1; code = scb; end
         @(posedge clk);
         #1;
         upd  = 1'b0;
         s[i] = pulse;
         if (pulse) w++;
      end
      pre = 1;
      for (int i = 0; i < 8; i++) begin
         if (s[i] != (i < w)) pre = 0;
      end
   endtask

   initial begin
      int w, pre;
      // reset state (R8)
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); #1;
         chk("R8 reset low", pulse, 0);
      end
      rst_n = 1'b1;
      // first frame: default code 0 (R8, R3)
      frame(-1, 0, -1, 0, w, pre);
      chk("R8 default width after reset", w, 4);
      chk("R3 first frame aligned", pre, 1);

      // table of codes strobed on the frame-start edge (R1, R4, R2, R6)
      for (int k = 0; k < 6; k++) begin
         frame(0, VEC[k][4:3], -1, 0, w, pre);
         chk("R1 width for code", w, int'(VEC[k][2:0]));
         chk("R2 contiguous pulse at frame start", pre, 1);
         frame(-1, 0, -1, 0, w, pre);
         chk("R6 stored code repeats", w, int'(VEC[k][2:0]));
      end

      // mid-frame strobe does not touch running pulse (R5, R4)
      frame(0, 2'd0, -1, 0, w, pre);
      chk("R1 code 0 width", w, 4);
      frame(2, 2'd1, -1, 0, w, pre);
      chk("R5 strobe during pulse leaves width", w, 4);
      chk("R2 pulse stays contiguous", pre, 1);
      frame(-1, 0, -1, 0, w, pre);
      chk("R4 mid-frame strobe applies next frame", w, 1);

      // two strobes in one frame: last wins (R7)
      frame(3, 2'd2, 6, 2'd3, w, pre);
      chk("R5 width unchanged by strobes", w, 1);
      frame(-1, 0, -1, 0, w, pre);
      chk("R7 last strobe wins", w, 3);

      // code input changes without strobe (R6)
      code = 2'd1;
      frame(-1, 0, -1, 0, w, pre);
      chk("R6 code change ignored", w, 3);
      code = 2'd2;
      frame(-1, 0, -1, 0, w, pre);
      chk("R6 code change ignored again", w, 3);

      // strobe on last edge of frame (R4)
      frame(7, 2'd2, -1, 0, w, pre);
      chk("R4 last-edge strobe not in current frame", w, 3);
      frame(-1, 0, -1, 0, w, pre);
      chk("R4 last-edge strobe applies next frame", w, 2);

      // reset in the middle of a pulse (R8)
      @(posedge clk); #1;
      chk("R9 pulse high after frame-start edge", pulse, 1);
      rst_n = 1'b0;
      #0.5;
      chk("R8 reset drops output at once", pulse, 0);
      for (int i = 0; i < 2; i++) begin
         @(posedge clk); #1;
         chk("R8 output held low in reset", pulse, 0);
      end
      rst_n = 1'b1;
      frame(-1, 0, -1, 0, w, pre);
      chk("R8 stored code cleared by reset", w, 4);
      chk("R8 frame position cleared by reset", pre, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule